// File: doc/BRIEF.md
# Precise Exception Pipeline Controller

This block is the exception control for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). Each of the first four stages has a fault detector, which the surrounding datapath supplies as a code input. The controller keeps a small record of every in-flight instruction: a valid bit, its PC and an exception field. When a stage reports a fault, the code is stored in that instruction's exception field and carried down the pipe with it. Every instruction younger than the faulting one becomes a bubble, so its register and memory writes are disabled, while the pipe keeps advancing.

Faults are resolved at one place, the memory stage. An instruction that reaches that stage with a nonzero exception field (or that faults there) is committed. Its code goes to the cause register and its PC goes to the exception-PC register. The privilege bit is set, the instruction is dropped, and fetch is redirected to the handler vector, which is built from an upper and a lower half. Because only the oldest instruction can commit, an older fault always wins over a younger instruction that faulted earlier in time.

An external interrupt code is accepted in user mode when no instruction exception commits in the same cycle. When it is accepted, the instruction in the memory stage completes, and everything younger is squashed and later refetched. An exception-return strobe in privileged mode clears the privilege bit and refetches from the saved PC. Every redirect is followed by one bubble cycle before the first new instruction is fetched.

The fetch sequencer has two states, listed in the table below.

| State | Meaning |
|---|---|
| ST_RUN | An instruction is fetched every cycle. The PC advances by 4. |
| ST_FLUSH | The bubble cycle after a redirect. Nothing is fetched and the PC holds the redirect target. |

These transitions connect the two states:

- ST_RUN to ST_FLUSH, on a redirect event.
- ST_FLUSH to ST_FLUSH, on a further redirect event.
- ST_RUN to ST_RUN, and ST_FLUSH to ST_RUN, when there is no event.

The redirect events are EV_EXC (an instruction exception commits), EV_IRQ (an external interrupt is taken) and EV_ERET (an exception return). EV_NONE means no event. If more than one could apply in a cycle, EV_EXC has priority over the other two.

Top module: `precise_exc_ctl`

## Requirements
- R1: During reset the outputs hold these values: the fetch PC equals the reset PC (0), fetch_valid_o is 1, and the privilege bit, the cause, the exception PC and wb_valid_o are all 0.
- R2: In ST_RUN with no event, the fetch PC increases by 4 every cycle. Each fetched instruction appears on the retire outputs (wb_valid_o=1, wb_pc_o=its PC) four cycles after the cycle in which it was fetched.
- R3: Fault codes are EXC_W bits wide. Code 0 means no fault, and a nonzero code has its most significant bit set. When an instruction with a nonzero code is in the memory stage, cause_o shows its code and epc_o shows its PC from the following cycle onwards.
- R4: A faulting instruction never retires, and neither does any instruction fetched after it before the redirect. Instructions older than it still retire.
- R5: Suppose a younger instruction faults in decode and the next-older instruction then faults in the memory stage on the following cycle. In that case the older instruction's code and PC are recorded, and the younger instruction is refetched after the return.
- R6: In the cycle after an exception commits, fetch_valid_o is 0 and the fetch PC is {VEC_HI, VEC_LO} (0xBFC00200 by default). The handler is fetched from that address on the next cycle.
- R7: Taking an exception or an interrupt sets the privilege bit in the following cycle.
- R8: A nonzero interrupt code taken in user mode is written to the cause register. The instruction in the memory stage still retires. The exception PC is set to the oldest valid instruction in execute, decode or fetch (or to the fetch PC if none of them holds one).
- R9: An interrupt code is ignored while the privilege bit is set. It is also ignored in a cycle in which an instruction exception commits. In both cases the cause keeps the exception's code.
- R10: An exception-return strobe in privileged mode clears the privilege bit. It is followed by one bubble cycle and then a fetch from the saved PC. The strobe is ignored in user mode.
- R11: An instruction keeps the first code reported for it. A later stage reporting a different code for the same instruction does not replace it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| if_fault_code | input | EXC_W | Fetch-stage fault code (0 = none) |
| id_fault_code | input | EXC_W | Decode-stage fault code |
| ex_fault_code | input | EXC_W | Execute-stage fault code |
| me_fault_code | input | EXC_W | Memory-stage fault code |
| irq_code | input | EXC_W | External interrupt code (0 = none) |
| eret_req | input | 1 | Exception-return strobe |
| fetch_pc_o | output | PC_W | Address being fetched |
| fetch_valid_o | output | 1 | A fetch happens this cycle |
| priv_o | output | 1 | Privileged mode |
| cause_o | output | EXC_W | Cause register |
| epc_o | output | PC_W | Exception-PC register |
| wb_valid_o | output | 1 | An instruction retires this cycle |
| wb_pc_o | output | PC_W | PC of the retiring instruction |

## Verification
A fault detected in any stage shows up in the cause and exception-PC registers one cycle after the instruction sits in the memory stage. The handler vector appears on the same cycle with fetch_valid_o low, and the first handler fetch follows one cycle later. An exception return produces the same one-cycle bubble before the saved PC is fetched. A retired instruction appears four cycles after its fetch.

A behavioural model in the bench follows the instruction stream and updates its state at each rising edge. All outputs are compared against the model at every falling edge, so each result is checked in exactly the cycle it is due. Directed checks wait for the privilege bit to rise and then read the recorded cause and PC. Stage faults are injected by matching the model's view of which PC sits in each stage.

// File: rtl/exc_ctl_pkg.sv
package exc_ctl_pkg;

    typedef enum logic [0:0] {
        ST_RUN,
        ST_FLUSH
    } fetch_state_e;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_EXC,
        EV_IRQ,
        EV_ERET
    } redirect_ev_e;

endpackage

// File: rtl/exc_stage_latch.sv
module exc_stage_latch #(
    parameter int PC_W  = 32,
    parameter int EXC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             up_valid,
    input  logic [PC_W-1:0]  up_pc,
    input  logic [EXC_W-1:0] up_exc,
    input  logic             kill,
    output logic             q_valid,
    output logic [PC_W-1:0]  q_pc,
    output logic [EXC_W-1:0] q_exc
);

    logic keep;

    assign keep = up_valid && !kill;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_valid <= 1'b0;
            q_pc    <= '0;
            q_exc   <= '0;
        end else begin
            q_valid <= keep;
            q_pc    <= up_pc;
            q_exc   <= keep ? up_exc : '0;
        end
    end

endmodule

// File: rtl/exc_order_resolve.sv
module exc_order_resolve #(
    parameter int EXC_W = 5,
    parameter int NSLOT = 4
) (
    input  logic [NSLOT-1:0]            slot_valid,
    input  logic [NSLOT-1:0][EXC_W-1:0] slot_exc,
    input  logic [NSLOT-1:0][EXC_W-1:0] det_code,
    output logic [NSLOT-1:0][EXC_W-1:0] eff_exc,
    output logic [NSLOT-1:0]            younger_kill,
    output logic                        check_fault
);

    logic [NSLOT-1:0] has_fault;
    logic             behind;

    always_comb begin
        for (int s = 0; s < NSLOT; s++) begin
            if (slot_exc[s] != '0) begin
                eff_exc[s] = slot_exc[s];
            end else if (slot_valid[s]) begin
                eff_exc[s] = det_code[s];
            end else begin
                eff_exc[s] = '0;
            end
            has_fault[s] = slot_valid[s] && (eff_exc[s] != '0);
        end
        behind = 1'b0;
        for (int s = NSLOT-1; s >= 0; s--) begin
            younger_kill[s] = behind;
            behind          = behind | has_fault[s];
        end
        check_fault = has_fault[NSLOT-1];
    end

endmodule

// File: rtl/exc_redirect_fsm.sv
module exc_redirect_fsm
    import exc_ctl_pkg::*;
#(
    parameter int                  PC_W     = 32,
    parameter int                  EXC_W    = 5,
    parameter logic [PC_W-1:0]     HANDLER  = 32'hBFC0_0200,
    parameter logic [PC_W-1:0]     RESET_PC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             me_fault,
    input  logic [EXC_W-1:0] me_code,
    input  logic [PC_W-1:0]  me_pc,
    input  logic [EXC_W-1:0] irq_code,
    input  logic             eret_req,
    input  logic [PC_W-1:0]  resume_pc,
    output logic [PC_W-1:0]  fetch_pc,
    output logic             fetch_valid,
    output logic             priv,
    output logic [EXC_W-1:0] cause,
    output logic [PC_W-1:0]  epc,
    output logic             flush
);

    localparam logic [PC_W-1:0] STEP = PC_W'(4);

    fetch_state_e state_q, state_d;
    redirect_ev_e ev;

    always_comb begin
        if (me_fault) begin
            ev = EV_EXC;
        end else if (!priv && (irq_code != '0)) begin
            ev = EV_IRQ;
        end else if (priv && eret_req) begin
            ev = EV_ERET;
        end else begin
            ev = EV_NONE;
        end
        flush = (ev != EV_NONE);
        unique case (state_q)
            ST_RUN:   state_d = flush ? ST_FLUSH : ST_RUN;
            ST_FLUSH: state_d = flush ? ST_FLUSH : ST_RUN;
            default:  state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fetch_pc <= RESET_PC;
            priv     <= 1'b0;
            cause    <= '0;
            epc      <= '0;
        end else begin
            unique case (ev)
                EV_EXC: begin
                    cause    <= me_code;
                    epc      <= me_pc;
                    priv     <= 1'b1;
                    fetch_pc <= HANDLER;
                end
                EV_IRQ: begin
                    cause    <= irq_code;
                    epc      <= resume_pc;
                    priv     <= 1'b1;
                    fetch_pc <= HANDLER;
                end
                EV_ERET: begin
                    priv     <= 1'b0;
                    fetch_pc <= epc;
                end
                EV_NONE: begin
                    if (state_q == ST_RUN) begin
                        fetch_pc <= fetch_pc + STEP;
                    end
                end
                default: begin
                    fetch_pc <= fetch_pc;
                end
            endcase
        end
    end

    assign fetch_valid = (state_q == ST_RUN);

    // R7
    take_sets_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (me_fault || (!priv && irq_code != '0)) |=> priv);

    // R6
    redirect_bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        me_fault |=> (!fetch_valid && fetch_pc == HANDLER));

    // R9
    irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (priv && !me_fault && !eret_req) |=> (priv && $stable(cause)));

    // R10
    eret_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (priv && eret_req && !me_fault) |=> (!priv && !fetch_valid && fetch_pc == $past(epc)));

    // R3
    code_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cause != '0) |-> cause[EXC_W-1]);

endmodule

// File: rtl/precise_exc_ctl.sv
module precise_exc_ctl #(
    parameter int                  PC_W     = 32,
    parameter int                  EXC_W    = 5,
    parameter logic [PC_W/2-1:0]   VEC_HI   = 'hBFC0,
    parameter logic [PC_W/2-1:0]   VEC_LO   = 'h0200,
    parameter logic [PC_W-1:0]     RESET_PC = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EXC_W-1:0] if_fault_code,
    input  logic [EXC_W-1:0] id_fault_code,
    input  logic [EXC_W-1:0] ex_fault_code,
    input  logic [EXC_W-1:0] me_fault_code,
    input  logic [EXC_W-1:0] irq_code,
    input  logic             eret_req,
    output logic [PC_W-1:0]  fetch_pc_o,
    output logic             fetch_valid_o,
    output logic             priv_o,
    output logic [EXC_W-1:0] cause_o,
    output logic [PC_W-1:0]  epc_o,
    output logic             wb_valid_o,
    output logic [PC_W-1:0]  wb_pc_o
);

    localparam int              NCHK    = 4;
    localparam int              NSLOT   = NCHK + 1;
    localparam int              ME_IDX  = NCHK - 1;
    localparam logic [PC_W-1:0] HANDLER = {VEC_HI, VEC_LO};

    logic             s_valid [NSLOT];
    logic [PC_W-1:0]  s_pc    [NSLOT];
    logic [EXC_W-1:0] s_exc   [NSLOT];

    logic [NCHK-1:0]            chk_valid;
    logic [NCHK-1:0][EXC_W-1:0] chk_exc;
    logic [NCHK-1:0][EXC_W-1:0] det_code;
    logic [NCHK-1:0][EXC_W-1:0] eff_exc;
    logic [NCHK-1:0]            younger_kill;
    logic [NCHK-1:0]            lat_kill;
    logic                       me_fault;
    logic                       flush;
    logic [PC_W-1:0]            resume_pc;
    logic [PC_W-1:0]            fetch_pc;
    logic                       fetch_valid;

    assign det_code = {me_fault_code, ex_fault_code, id_fault_code, if_fault_code};

    assign s_valid[0] = fetch_valid;
    assign s_pc[0]    = fetch_pc;
    assign s_exc[0]   = '0;

    always_comb begin
        for (int i = 0; i < NCHK; i++) begin
            chk_valid[i] = s_valid[i];
            chk_exc[i]   = s_exc[i];
            lat_kill[i]  = (i == ME_IDX) ? me_fault : (younger_kill[i] || flush);
        end
    end

    exc_order_resolve #(
        .EXC_W (EXC_W),
        .NSLOT (NCHK)
    ) u_resolve (
        .slot_valid   (chk_valid),
        .slot_exc     (chk_exc),
        .det_code     (det_code),
        .eff_exc      (eff_exc),
        .younger_kill (younger_kill),
        .check_fault  (me_fault)
    );

    for (genvar g = 0; g < NCHK; g++) begin : g_lat
        exc_stage_latch #(
            .PC_W  (PC_W),
            .EXC_W (EXC_W)
        ) u_lat (
            .clk      (clk),
            .rst_n    (rst_n),
            .up_valid (s_valid[g]),
            .up_pc    (s_pc[g]),
            .up_exc   (eff_exc[g]),
            .kill     (lat_kill[g]),
            .q_valid  (s_valid[g+1]),
            .q_pc     (s_pc[g+1]),
            .q_exc    (s_exc[g+1])
        );
    end

    always_comb begin
        if (s_valid[2]) begin
            resume_pc = s_pc[2];
        end else if (s_valid[1]) begin
            resume_pc = s_pc[1];
        end else begin
            resume_pc = fetch_pc;
        end
    end

    exc_redirect_fsm #(
        .PC_W     (PC_W),
        .EXC_W    (EXC_W),
        .HANDLER  (HANDLER),
        .RESET_PC (RESET_PC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .me_fault    (me_fault),
        .me_code     (eff_exc[ME_IDX]),
        .me_pc       (s_pc[ME_IDX]),
        .irq_code    (irq_code),
        .eret_req    (eret_req),
        .resume_pc   (resume_pc),
        .fetch_pc    (fetch_pc),
        .fetch_valid (fetch_valid),
        .priv        (priv_o),
        .cause       (cause_o),
        .epc         (epc_o),
        .flush       (flush)
    );

    assign fetch_pc_o    = fetch_pc;
    assign fetch_valid_o = fetch_valid;
    assign wb_valid_o    = s_valid[NCHK];
    assign wb_pc_o       = s_pc[NCHK];

    // R4
    retire_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid_o |-> (s_exc[NCHK] == '0));

    // R4
    me_fault_dropped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        me_fault |=> !wb_valid_o);

endmodule

// File: tb/precise_exc_ctl_tb_top.sv
module precise_exc_ctl_tb_top;

    localparam logic [31:0] VEC = 32'hBFC0_0200;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  det [4];
    logic [4:0]  irq_code;
    logic        eret_req;
    logic [31:0] fetch_pc_o, epc_o, wb_pc_o;
    logic        fetch_valid_o, priv_o, wb_valid_o;
    logic [4:0]  cause_o;

    always #10 clk = ~clk;

    precise_exc_ctl dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .if_fault_code (det[0]),
        .id_fault_code (det[1]),
        .ex_fault_code (det[2]),
        .me_fault_code (det[3]),
        .irq_code      (irq_code),
        .eret_req      (eret_req),
        .fetch_pc_o    (fetch_pc_o),
        .fetch_valid_o (fetch_valid_o),
        .priv_o        (priv_o),
        .cause_o       (cause_o),
        .epc_o         (epc_o),
        .wb_valid_o    (wb_valid_o),
        .wb_pc_o       (wb_pc_o)
    );

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit compare_on = 1'b0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference: one record per occupied stage
    bit          m_v  [5];
    logic [31:0] m_pc [5];
    logic [4:0]  m_ex [5];
    bit          m_run;
    logic [31:0] m_fetch;
    bit          m_priv;
    logic [4:0]  m_cause;
    logic [31:0] m_epc;

    bit          cv  [4];
    logic [31:0] cpc [4];
    logic [4:0]  cex [4];
    int          oldest;
    bit          t_exc, t_irq, t_eret, t_any;
    logic [31:0] t_resume;

    int          inj_n = 0;
    int          inj_stage [16];
    logic [31:0] inj_pc    [16];
    logic [4:0]  inj_code  [16];
    bit          inj_used  [16];

    task automatic add_inj(input int stg, input logic [31:0] pc, input logic [4:0] code);
        inj_stage[inj_n] = stg;
        inj_pc[inj_n]    = pc;
        inj_code[inj_n]  = code;
        inj_used[inj_n]  = 1'b0;
        inj_n++;
    endtask

    task automatic model_reset();
        for (int s = 0; s < 5; s++) begin
            m_v[s] = 1'b0; m_pc[s] = '0; m_ex[s] = '0;
        end
        m_run = 1'b1; m_fetch = '0; m_priv = 1'b0; m_cause = '0; m_epc = '0;
    endtask

    initial model_reset();

    always @(posedge clk) begin
        if (!rst_n) begin
            model_reset();
        end else begin
            cv[0] = m_run; cpc[0] = m_fetch; cex[0] = '0;
            for (int s = 1; s < 4; s++) begin
                cv[s] = m_v[s]; cpc[s] = m_pc[s]; cex[s] = m_ex[s];
            end
            oldest = -1;
            for (int s = 0; s < 4; s++) begin
                if (cex[s] == 0 && cv[s]) cex[s] = det[s];
                if (cv[s] && cex[s] != 0) oldest = s;
            end
            t_exc  = (oldest == 3);
            t_irq  = !t_exc && !m_priv && (irq_code != 0);
            t_eret = !t_exc && m_priv && eret_req;
            t_any  = t_exc || t_irq || t_eret;
            t_resume = cv[2] ? cpc[2] : (cv[1] ? cpc[1] : m_fetch);
            m_v[4]  = cv[3] && !t_exc;
            m_pc[4] = cpc[3];
            m_ex[4] = '0;
            for (int s = 0; s < 3; s++) begin
                m_v[s+1]  = cv[s] && !t_any && !(oldest > s);
                m_pc[s+1] = cpc[s];
                m_ex[s+1] = m_v[s+1] ? cex[s] : 5'd0;
            end
            if (t_exc) begin
                m_cause = cex[3]; m_epc = cpc[3]; m_priv = 1'b1; m_fetch = VEC; m_run = 1'b0;
            end else if (t_irq) begin
                m_cause = irq_code; m_epc = t_resume; m_priv = 1'b1; m_fetch = VEC; m_run = 1'b0;
            end else if (t_eret) begin
                m_priv = 1'b0; m_fetch = m_epc; m_run = 1'b0;
            end else begin
                if (m_run) m_fetch = m_fetch + 32'd4;
                m_run = 1'b1;
            end
        end
    end

    // compare every cycle, then drive stage faults for the coming edge
    always @(negedge clk) begin
        if (compare_on) begin
            chk("R2 R6 fetch_pc", fetch_pc_o, m_fetch);
            chk("R6 R10 fetch_valid", {31'd0, fetch_valid_o}, {31'd0, m_run});
            chk("R7 R10 priv", {31'd0, priv_o}, {31'd0, m_priv});
            chk("R3 R8 cause", {27'd0, cause_o}, {27'd0, m_cause});
            chk("R3 R8 epc", epc_o, m_epc);
            chk("R2 R4 wb_valid", {31'd0, wb_valid_o}, {31'd0, m_v[4]});
            if (m_v[4]) chk("R2 R4 wb_pc", wb_pc_o, m_pc[4]);
        end
        for (int s = 0; s < 4; s++) begin
            det[s] = '0;
            for (int i = 0; i < inj_n; i++) begin
                if (!inj_used[i] && inj_stage[i] == s &&
                    ((s == 0) ? (m_run && m_fetch == inj_pc[i]) : (m_v[s] && m_pc[s] == inj_pc[i]))) begin
                    det[s] = inj_code[i];
                    inj_used[i] = 1'b1;
                end
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic wait_priv(input bit level, input string tag);
        for (int n = 0; n < 80; n++) begin
            @(negedge clk);
            if (priv_o == level) return;
        end
        failures++;
        $display("FAIL %s timeout waiting priv actual=%0b expected=%0b", tag, priv_o, level);
    endtask

    task automatic do_return(input logic [31:0] ret_pc);
        repeat (3) @(negedge clk);
        eret_req = 1'b1;
        @(negedge clk);
        eret_req = 1'b0;
        chk("R10 priv cleared", {31'd0, priv_o}, 32'd0);
        chk("R10 bubble", {31'd0, fetch_valid_o}, 32'd0);
        chk("R10 refetch pc", fetch_pc_o, ret_pc);
        @(negedge clk);
        chk("R10 refetch valid", {31'd0, fetch_valid_o}, 32'd1);
        chk("R10 refetch pc next", fetch_pc_o, ret_pc);
        repeat (6) @(negedge clk);
    endtask

    logic [31:0] p;

    initial begin
        rst_n = 1'b0; irq_code = '0; eret_req = 1'b0;
        for (int s = 0; s < 4; s++) det[s] = '0;
        repeat (3) @(negedge clk);
        chk("R1 fetch_pc", fetch_pc_o, 32'd0);
        chk("R1 fetch_valid", {31'd0, fetch_valid_o}, 32'd1);
        chk("R1 priv", {31'd0, priv_o}, 32'd0);
        chk("R1 cause", {27'd0, cause_o}, 32'd0);
        chk("R1 epc", epc_o, 32'd0);
        chk("R1 wb_valid", {31'd0, wb_valid_o}, 32'd0);
        rst_n = 1'b1;
        compare_on = 1'b1;

        // R2 steady retire four cycles behind fetch
        while (fetch_pc_o != 32'h28) @(negedge clk);
        chk("R2 retire lag valid", {31'd0, wb_valid_o}, 32'd1);
        chk("R2 retire lag pc", wb_pc_o, 32'h18);

        // memory-stage fault, then interrupt while privileged
        add_inj(3, 32'h40, 5'h11);
        wait_priv(1'b1, "R3");
        chk("R3 cause", {27'd0, cause_o}, 32'h11);
        chk("R3 epc", epc_o, 32'h40);
        chk("R6 vector", fetch_pc_o, VEC);
        chk("R6 bubble", {31'd0, fetch_valid_o}, 32'd0);
        chk("R4 faulting not retired", {31'd0, wb_valid_o}, 32'd0);
        @(negedge clk);
        chk("R6 handler fetch", fetch_pc_o, VEC);
        chk("R6 handler valid", {31'd0, fetch_valid_o}, 32'd1);
        irq_code = 5'h1A;
        repeat (3) @(negedge clk);
        irq_code = '0;
        chk("R9 irq masked cause", {27'd0, cause_o}, 32'h11);
        do_return(32'h40);

        // younger decode fault, older memory fault next cycle
        p = fetch_pc_o + 32'h20;
        add_inj(3, p, 5'h13);
        add_inj(1, p + 32'd4, 5'h12);
        wait_priv(1'b1, "R5");
        chk("R5 older cause", {27'd0, cause_o}, 32'h13);
        chk("R5 older epc", epc_o, p);
        do_return(p);

        // first code sticks
        p = fetch_pc_o + 32'h20;
        add_inj(0, p, 5'h14);
        add_inj(2, p, 5'h15);
        wait_priv(1'b1, "R11");
        chk("R11 first code", {27'd0, cause_o}, 32'h14);
        chk("R11 epc", epc_o, p);
        do_return(p);

        // user-mode interrupt
        p = fetch_pc_o;
        irq_code = 5'h1B;
        @(negedge clk);
        irq_code = '0;
        chk("R8 cause", {27'd0, cause_o}, 32'h1B);
        chk("R7 priv after irq", {31'd0, priv_o}, 32'd1);
        chk("R8 resume epc", epc_o, p - 32'd8);
        chk("R8 memory-stage retires", wb_pc_o, p - 32'd12);
        chk("R8 retire valid", {31'd0, wb_valid_o}, 32'd1);
        do_return(p - 32'd8);

        // interrupt in the same cycle as an exception commit
        p = fetch_pc_o + 32'h20;
        add_inj(3, p, 5'h16);
        for (int n = 0; n < 40; n++) begin
            @(negedge clk);
            if (m_v[3] && m_pc[3] == p) break;
        end
        irq_code = 5'h1C;
        @(negedge clk);
        irq_code = '0;
        chk("R9 exc wins cause", {27'd0, cause_o}, 32'h16);
        chk("R9 exc wins epc", epc_o, p);
        do_return(p);

        // return strobe in user mode
        p = fetch_pc_o;
        eret_req = 1'b1;
        @(negedge clk);
        eret_req = 1'b0;
        chk("R10 user eret ignored priv", {31'd0, priv_o}, 32'd0);
        chk("R10 user eret ignored valid", {31'd0, fetch_valid_o}, 32'd1);
        chk("R10 user eret ignored pc", fetch_pc_o, p + 32'd4);

        repeat (10) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule